// File: doc/BRIEF.md
# Field and Vertical Sync Timing Generator

This block derives the field flag and the vertical sync flag of an interlaced 525-line or 625-line video stream from a line number and a line-start strobe supplied by an external line counter. Each flag changes state at two edge lines per frame. Every edge line sits at a nominal reference line, shifted by a programmable sign-magnitude offset. A per-field-parity control can add one further line of delay to that shift.

Three 8-bit control registers, one for the field toggle, one for the start of vsync and one for the end of vsync, are written through a byte-wide write port. A write is held in a pending copy and becomes active only at the next frame boundary, so a field in progress is never disturbed. Each flag is driven on two outputs that always agree: one feeds the timing-code bit generator and one drives a pin.

Top module: `field_vsync_gen`

## Requirements
- R1: After reset, all four flag outputs are 0 and the 525-line standard is active. The control registers reset as follows (bit 7 odd-extra, bit 6 even-extra, bit 5 advance, bits 4:0 magnitude): field 0x63, vsync start 0x25, vsync end 0x22.
- R2: In each control byte, bits 4:0 hold an offset magnitude and bit 5 a direction. Bit 5 = 1 places the edge that many lines before the reference line, and 0 places it after.
- R3: The edge at reference line A takes one more line of delay when bit 6 is set. The edge at reference line B takes one more line of delay when bit 7 is set.
- R4: A computed edge line outside 1..frame length wraps by one frame length, so an advance past line 1 lands near the end of the frame.
- R5: The field flag falls to 0 on the field edge line A and rises to 1 on the field edge line B.
- R6: The vsync flag rises on either vsync-start edge line and falls on either vsync-end edge line. When both fall on the same line, the rise wins.
- R7: field_bit always equals field_pin, and vbit always equals vs_pin.
- R8: The flags change only in the clock cycle after a line_start strobe. A line number presented without the strobe has no effect.
- R9: Writes and the std_pal level take effect at the first line_start strobe with line_num = 1 after them. That strobe's own line is already evaluated with the new settings.
- R10: wr_addr 0 selects the field register, 1 selects vsync start and 2 selects vsync end. Address 3 is ignored.
- R11: With std_pal = 0 the reference lines are 4 (A) and 266 (B) in a 525-line frame. With std_pal = 1 they are 1 (A) and 313 (B) in a 625-line frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| std_pal | input | 1 | 0 selects 525-line timing, 1 selects 625-line timing |
| line_start | input | 1 | One-cycle strobe at the start of each line |
| line_num | input | 10 | Current line number, counted from 1 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 8 | Register write data |
| field_bit | output | 1 | Field flag for the timing-code F bit |
| vbit | output | 1 | Vsync flag for the timing-code V bit |
| field_pin | output | 1 | Field flag for the FIELD pin |
| vs_pin | output | 1 | Vsync flag for the VS pin |

## Verification
Both flags are registered once: the new value for a line is visible one clock after the clock edge that samples line_start, and nothing changes in any other cycle. The bench drives each strobe at a falling edge and samples the outputs at the next falling edge, half a cycle after the registering edge. It logs the line at which each flag changed. A register write is checked through whole frames, because its effect is due only from the next line-1 strobe. The rest of the current frame must therefore still show the old edge lines.

// File: rtl/fvtg_pkg.sv
package fvtg_pkg;

    // one edge-pair control byte
    typedef struct packed {
        logic       odd_x;   // extra line on edge near reference B
        logic       even_x;  // extra line on edge near reference A
        logic       adv;     // 1 = earlier, 0 = later
        logic [4:0] mag;
    } edge_ctl_t;

    typedef struct packed {
        edge_ctl_t fld;
        edge_ctl_t vbeg;
        edge_ctl_t vend;
        logic      pal;
    } cfg_t;

    localparam edge_ctl_t FLD_RST  = 8'h63;
    localparam edge_ctl_t VBEG_RST = 8'h25;
    localparam edge_ctl_t VEND_RST = 8'h22;

    localparam logic [1:0] ADDR_FLD  = 2'd0;
    localparam logic [1:0] ADDR_VBEG = 2'd1;
    localparam logic [1:0] ADDR_VEND = 2'd2;

endpackage

// File: rtl/fvtg_regs.sv
module fvtg_regs
    import fvtg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       std_pal,
    input  logic       frame_start,
    output cfg_t       cfg_eff
);

    typedef struct packed {
        cfg_t pend;
        cfg_t act;
    } reg_st_t;

    reg_st_t st_d, st_q;
    cfg_t    pend_now;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (wr_addr)
                ADDR_FLD:  st_d.pend.fld  = edge_ctl_t'(wr_data);
                ADDR_VBEG: st_d.pend.vbeg = edge_ctl_t'(wr_data);
                ADDR_VEND: st_d.pend.vend = edge_ctl_t'(wr_data);
                default:   ;
            endcase
        end
        pend_now     = st_q.pend;
        pend_now.pal = std_pal;
        if (frame_start) st_d.act = pend_now;
        cfg_eff = frame_start ? pend_now : st_q.act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pend <= '{fld: FLD_RST, vbeg: VBEG_RST, vend: VEND_RST, pal: 1'b0};
            st_q.act  <= '{fld: FLD_RST, vbeg: VBEG_RST, vend: VEND_RST, pal: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    // R9: active settings move only at a frame boundary
    p_hold_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(st_q.act));

    // R10: address 3 touches no register
    p_addr3_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd3) |=> $stable(st_q.pend));

endmodule

// File: rtl/fvtg_edge.sv
module fvtg_edge
    import fvtg_pkg::*;
#(
    parameter int LW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  edge_ctl_t     ctl,
    input  logic [LW-1:0] ref_a,
    input  logic [LW-1:0] ref_b,
    input  logic [LW-1:0] frame_len,
    output logic [LW-1:0] line_a,
    output logic [LW-1:0] line_b
);

    function automatic logic [LW-1:0] wrap_line(input int t, input int n);
        int r;
        r = t;
        if (r < 1)      r = r + n;
        else if (r > n) r = r - n;
        return LW'(r);
    endfunction

    always_comb begin
        int off;
        int n;
        n   = int'(frame_len);
        off = ctl.adv ? -int'(ctl.mag) : int'(ctl.mag);
        line_a = wrap_line(int'(ref_a) + off + int'(ctl.even_x), n);
        line_b = wrap_line(int'(ref_b) + off + int'(ctl.odd_x), n);
    end

    // R4: both computed lines stay inside the frame
    p_line_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (line_a >= 1) && (line_a <= frame_len) && (line_b >= 1) && (line_b <= frame_len));

endmodule

// File: rtl/field_vsync_gen.sv
module field_vsync_gen
    import fvtg_pkg::*;
#(
    parameter int LW         = 10,
    parameter int NTSC_LINES = 525,
    parameter int PAL_LINES  = 625,
    parameter int NTSC_REF_A = 4,
    parameter int NTSC_REF_B = 266,
    parameter int PAL_REF_A  = 1,
    parameter int PAL_REF_B  = 313
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          std_pal,
    input  logic          line_start,
    input  logic [LW-1:0] line_num,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [7:0]    wr_data,
    output logic          field_bit,
    output logic          vbit,
    output logic          field_pin,
    output logic          vs_pin
);

    localparam int N_EDGES = 3;
    localparam int E_FLD   = 0;
    localparam int E_VBEG  = 1;
    localparam int E_VEND  = 2;

    typedef struct packed {
        logic field;
        logic vs;
    } out_st_t;

    out_st_t       st_d, st_q;
    cfg_t          cfg_eff;
    logic          frame_start;
    logic [LW-1:0] ref_a, ref_b, frame_len;
    edge_ctl_t     ctl   [N_EDGES];
    logic [LW-1:0] ln_a  [N_EDGES];
    logic [LW-1:0] ln_b  [N_EDGES];

    assign frame_start = line_start && (line_num == LW'(1));

    fvtg_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .std_pal     (std_pal),
        .frame_start (frame_start),
        .cfg_eff     (cfg_eff)
    );

    assign ref_a     = cfg_eff.pal ? LW'(PAL_REF_A)  : LW'(NTSC_REF_A);
    assign ref_b     = cfg_eff.pal ? LW'(PAL_REF_B)  : LW'(NTSC_REF_B);
    assign frame_len = cfg_eff.pal ? LW'(PAL_LINES)  : LW'(NTSC_LINES);

    assign ctl[E_FLD]  = cfg_eff.fld;
    assign ctl[E_VBEG] = cfg_eff.vbeg;
    assign ctl[E_VEND] = cfg_eff.vend;

    for (genvar g = 0; g < N_EDGES; g++) begin : g_edge
        fvtg_edge #(.LW(LW)) u_edge (
            .clk       (clk),
            .rst_n     (rst_n),
            .ctl       (ctl[g]),
            .ref_a     (ref_a),
            .ref_b     (ref_b),
            .frame_len (frame_len),
            .line_a    (ln_a[g]),
            .line_b    (ln_b[g])
        );
    end

    always_comb begin
        st_d = st_q;
        if (line_start) begin
            if (line_num == ln_a[E_FLD])      st_d.field = 1'b0;
            else if (line_num == ln_b[E_FLD]) st_d.field = 1'b1;
            if (line_num == ln_a[E_VEND] || line_num == ln_b[E_VEND]) st_d.vs = 1'b0;
            if (line_num == ln_a[E_VBEG] || line_num == ln_b[E_VBEG]) st_d.vs = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign field_bit = st_q.field;
    assign field_pin = st_q.field;
    assign vbit      = st_q.vs;
    assign vs_pin    = st_q.vs;

    // R8: no flag change without a line strobe
    p_quiet_between_lines_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !line_start |=> ($stable(st_q.field) && $stable(st_q.vs)));

    // R5: field falls on edge A
    p_field_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && line_num == ln_a[E_FLD]) |=> !st_q.field);

    // R5: field rises on edge B
    p_field_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && line_num == ln_b[E_FLD] && line_num != ln_a[E_FLD]) |=> st_q.field);

    // R6: vsync start lines always leave the flag high
    p_vs_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && (line_num == ln_a[E_VBEG] || line_num == ln_b[E_VBEG])) |=> st_q.vs);

endmodule

// File: tb/field_vsync_gen_bench.sv
module field_vsync_gen_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       std_pal = 1'b0;
    logic       line_start = 1'b0;
    logic [9:0] line_num = 10'd1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       field_bit, vbit, field_pin, vs_pin;

    int n_checks = 0;
    int n_fail = 0;
    int pair_err = 0;
    bit done = 1'b0;

    int flog [8];
    int vlog [8];
    int nf, nv;

    always #5 clk = ~clk;

    field_vsync_gen u_field_vsync_gen (
        .clk(clk), .rst_n(rst_n), .std_pal(std_pal), .line_start(line_start),
        .line_num(line_num), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .field_bit(field_bit), .vbit(vbit), .field_pin(field_pin), .vs_pin(vs_pin)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_logs();
        nf = 0; nv = 0;
        for (int i = 0; i < 8; i++) begin flog[i] = 0; vlog[i] = 0; end
    endtask

    // one line: strobe at a falling edge, sample at the next falling edge
    task automatic step_line(input int ln);
        logic pf, pv;
        pf = field_pin; pv = vs_pin;
        line_num = 10'(ln);
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        if (field_bit !== field_pin || vbit !== vs_pin) pair_err++;
        if (field_pin !== pf && nf < 8) begin flog[nf] = field_pin ? ln : -ln; nf++; end
        if (vs_pin !== pv && nv < 8) begin vlog[nv] = vs_pin ? ln : -ln; nv++; end
        @(negedge clk);
    endtask

    task automatic run_lines(input int first, input int last);
        for (int ln = first; ln <= last; ln++) step_line(ln);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic check_logs(input string req, input int ef[8], input int nef,
                              input int ev[8], input int nev);
        chk({req, " field edge count"}, nf, nef);
        for (int i = 0; i < nef; i++) chk({req, " field edge line"}, flog[i], ef[i]);
        chk({req, " vsync edge count"}, nv, nev);
        for (int i = 0; i < nev; i++) chk({req, " vsync edge line"}, vlog[i], ev[i]);
    endtask

    task automatic t_reset();
        chk("R1 field_pin", int'(field_pin), 0);
        chk("R1 field_bit", int'(field_bit), 0);
        chk("R1 vs_pin", int'(vs_pin), 0);
        chk("R1 vbit", int'(vbit), 0);
    endtask

    // R1 R2 R3 R4 R5 R6 R11: reset settings in 525-line mode
    task automatic t_ntsc_default();
        run_lines(1, 525);
        clear_logs();
        run_lines(1, 525);
        check_logs("R1 R2 R3 R4 R5 R6 R11 ntsc default",
                   '{-2, 263, 0, 0, 0, 0, 0, 0}, 2,
                   '{-2, 261, -264, 524, 0, 0, 0, 0}, 4);
    endtask

    // R8: edge line presented without a strobe
    task automatic t_no_strobe();
        line_num = 10'd2;
        repeat (5) @(negedge clk);
        chk("R8 field held without strobe", int'(field_pin), 1);
        chk("R8 vsync held without strobe", int'(vs_pin), 1);
    endtask

    // R9 R11: std_pal picked up at line 1, 625-line defaults
    task automatic t_pal_default();
        std_pal = 1'b1;
        run_lines(1, 625);
        clear_logs();
        run_lines(1, 625);
        check_logs("R4 R9 R11 pal default",
                   '{310, -624, 0, 0, 0, 0, 0, 0}, 2,
                   '{308, -311, 621, -624, 0, 0, 0, 0}, 4);
    endtask

    // R9 R10 R2 R3: deferred write of delay settings, address 3 ignored
    task automatic t_pal_deferred_write();
        run_lines(1, 100);
        wr(2'd1, 8'h41);
        wr(2'd2, 8'h84);
        wr(2'd0, 8'h06);
        wr(2'd3, 8'hFF);
        clear_logs();
        run_lines(101, 625);
        check_logs("R9 rest of frame unchanged",
                   '{310, -624, 0, 0, 0, 0, 0, 0}, 2,
                   '{308, -311, 621, -624, 0, 0, 0, 0}, 4);
        run_lines(1, 625);
        clear_logs();
        run_lines(1, 625);
        check_logs("R2 R3 R10 pal delay settings",
                   '{-7, 319, 0, 0, 0, 0, 0, 0}, 2,
                   '{3, -5, 314, -318, 0, 0, 0, 0}, 4);
    endtask

    // R4 R3 R11: large advance wraps, odd-extra on edge B
    task automatic t_ntsc_wrap();
        std_pal = 1'b0;
        wr(2'd0, 8'h9F);
        wr(2'd1, 8'h3F);
        wr(2'd2, 8'h20);
        run_lines(1, 525);
        clear_logs();
        run_lines(1, 525);
        check_logs("R4 R3 R11 ntsc wrap",
                   '{-35, 298, 0, 0, 0, 0, 0, 0}, 2,
                   '{-4, 235, -266, 498, 0, 0, 0, 0}, 4);
    endtask

    // R6: start and end on the same lines, rise wins
    task automatic t_same_line();
        wr(2'd1, 8'h20);
        run_lines(1, 525);
        clear_logs();
        run_lines(1, 525);
        chk("R6 no vsync edges when start equals end", nv, 0);
        chk("R6 vsync stays high", int'(vs_pin), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        clear_logs();
        t_reset();
        t_ntsc_default();
        t_no_strobe();
        t_pal_default();
        t_pal_deferred_write();
        t_ntsc_wrap();
        t_same_line();
        chk("R7 paired outputs mismatches", pair_err, 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule